// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into an absolute address. It reads up to five levels of translation tables through a read port with a request/response handshake. A request carries the virtual address, a write flag, a 64-bit address-space control word and two feature enables, one for large segments and one for large regions. The walker decides where the walk starts, reads one table entry at a time and checks each entry as it arrives. It finishes with either the translated address or an exception code, which it reports on a one-cycle done pulse.

The virtual address is cut, from the most significant end, into four 11-bit table indices (bits 63:53 first-region, 52:42 second-region, 41:31 third-region, 30:20 segment), an 8-bit page index (19:12) and a 12-bit byte offset (11:0). The walk can begin at any of the four upper levels. A large-region or large-segment entry can end it early. Protection bits are collected along the way, and a write to a protected result is refused.

Control word layout: origin in bits 63:12, real-space bit 5, start type in bits 3:2 (0 segment, 1 third-region, 2 second-region, 3 first-region), table length in bits 1:0. Region and segment entries: invalid bit 5, type bits 3:2 (same code as their level), protection bit 9, format bit 10. Region entries also carry a table offset in bits 7:6 and a table length in bits 1:0. Page entries: invalid bit 10, zero bit 11, protection bit 9, change-override bit 8.

Top module: `addrWalker`

## Requirements
- R1: With control-word bit 5 set, the walker makes no table read and completes with code 0 and the virtual address unchanged.
- R2: A nonzero index at any level above the start level gives code 1 (space type) with no table read.
- R3: If the top two bits of the start-level index exceed control-word bits 1:0, the walk ends with no table read, giving that level's translation code: 2 first-region, 3 second-region, 4 third-region, 5 segment.
- R4: Each read address is the table origin with its low 12 bits cleared, plus index×8. The page-table read instead clears the low 11 bits of segment-entry bits 63:11 and adds page index×8. Every read address is 8-byte aligned.
- R5: An entry with its invalid bit set ends the walk with its own level's code (page: 6). A region or segment entry whose type bits differ from its level gives code 7.
- R6: After a region entry, the next index's top two bits must lie between that entry's offset (bits 7:6) and length (bits 1:0). Otherwise the walk ends with the next level's translation code.
- R7: When the large-region enable is on and the third-region entry's bit 10 is set, the result is entry bits 63:31 joined with virtual bits 30:0.
- R8: When the large-segment enable is on and the segment entry's bit 10 is set, the result is entry bits 63:20 joined with virtual bits 19:0. Otherwise a page entry is read, and the result is its bits 63:12 joined with virtual bits 11:0.
- R9: Protection is the OR of the segment and page protection bits, of any large-frame entry's protection bit, and of the region entries' protection bits when the large-segment enable is on. A write with protection set gives code 8. Every nonzero code returns address 0.
- R10: A page entry with its zero bit set, or with its change-override bit set while the large-segment enable is off, gives code 7.
- R11: Requests are taken only while ready is high (idle). At most one read is outstanding, and its request and address are held until accepted. Done lasts exactly one cycle.
- R12: After reset the walker is idle, with ready high and done and read request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request |
| reqReady | output | 1 | Walker idle, request taken |
| reqWrite | input | 1 | Access is a write |
| reqVaddr | input | 64 | Virtual address |
| reqAsce | input | 64 | Address-space control word |
| largeSegEn | input | 1 | Large-segment enable |
| largeRegEn | input | 1 | Large-region enable |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Table read accepted |
| memReqAddr | output | 64 | Table entry address |
| memRspValid | input | 1 | Table data valid |
| memRspData | input | 64 | Table entry |
| done | output | 1 | One-cycle completion pulse |
| doneAddr | output | 64 | Translated absolute address |
| doneExc | output | 4 | Exception code, 0 for none |

## Verification
The bench targets walks that start at each of the four levels. A walker that miscounted the start level would read the wrong table, or would let a nonzero upper index pass instead of raising code 1. Offset and length bounds are tested on both sides. A swapped comparison would report the wrong level, or would read an entry that should never be fetched. Large-frame exits are run with their enables both on and off, as are region protection bits with the large-segment enable both ways, and page zero and override bits. Every table read address is compared against an independent model, so a wrong shift on the 2048-byte page-table origin shows up as a misplaced read.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W        = 64;
  localparam int IDX_W       = 11;
  localparam int PX_W        = 8;
  localparam int BX_W        = 12;
  localparam int IDX_LEVELS  = 4;
  localparam int SX_LSB      = BX_W + PX_W;
  localparam int RT_LSB      = SX_LSB + IDX_W;
  localparam int TBL_SHIFT   = 12;
  localparam int PT_SHIFT    = 11;
  localparam int ENT_SHIFT   = 3;

  localparam logic [VA_W-1:0] TBL_MASK  = ~((VA_W'(1) << TBL_SHIFT) - VA_W'(1));
  localparam logic [VA_W-1:0] PT_MASK   = ~((VA_W'(1) << PT_SHIFT) - VA_W'(1));
  localparam logic [VA_W-1:0] RFR_MASK  = ~((VA_W'(1) << RT_LSB) - VA_W'(1));
  localparam logic [VA_W-1:0] SFR_MASK  = ~((VA_W'(1) << SX_LSB) - VA_W'(1));
  localparam logic [VA_W-1:0] PFR_MASK  = ~((VA_W'(1) << BX_W) - VA_W'(1));

  localparam int B_REAL   = 5;
  localparam int B_INV    = 5;
  localparam int B_PROT   = 9;
  localparam int B_FC     = 10;
  localparam int B_PGINV  = 10;
  localparam int B_ZERO   = 11;
  localparam int B_CRO    = 8;
  localparam int TT_LSB   = 2;
  localparam int TF_LSB   = 6;
  localparam int TL_LSB   = 0;

  typedef enum logic [3:0] {
    EXC_NONE      = 4'd0,
    EXC_SPACETYPE = 4'd1,
    EXC_REGION1   = 4'd2,
    EXC_REGION2   = 4'd3,
    EXC_REGION3   = 4'd4,
    EXC_SEGMENT   = 4'd5,
    EXC_PAGE      = 4'd6,
    EXC_SPEC      = 4'd7,
    EXC_PROT      = 4'd8
  } excCode_e;

  typedef enum logic [2:0] {
    LV_SEG  = 3'd0,
    LV_RT   = 3'd1,
    LV_RS   = 3'd2,
    LV_RF   = 3'd3,
    LV_PAGE = 3'd4
  } level_e;

  typedef struct packed {
    logic capture;
    logic applyStart;
    logic applyEntry;
  } strobe_t;

  typedef struct packed {
    logic            fin;
    excCode_e        exc;
    logic [VA_W-1:0] addr;
    logic [VA_W-1:0] ptr;
    level_e          level;
    logic            prot;
  } step_t;

  function automatic excCode_e levelExc(input level_e lv);
    case (lv)
      LV_RF:   return EXC_REGION1;
      LV_RS:   return EXC_REGION2;
      LV_RT:   return EXC_REGION3;
      LV_SEG:  return EXC_SEGMENT;
      default: return EXC_PAGE;
    endcase
  endfunction
endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    startFin,
  input  logic    entryFin,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    done,
  output strobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ISSUE, ST_WAIT, ST_FINISH
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_START;
        end
      end
      ST_START: begin
        strobe.applyStart = 1'b1;
        stateNext         = startFin ? ST_FINISH : ST_ISSUE;
      end
      ST_ISSUE: begin
        if (memReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.applyEntry = 1'b1;
          stateNext         = entryFin ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign done        = (state == ST_FINISH);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_read_while_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !memReqValid);
endmodule

// File: rtl/walkPath.sv
module walkPath
  import walk_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [VA_W-1:0] reqAsce,
  input  logic            reqWrite,
  input  logic            largeSegEn,
  input  logic            largeRegEn,
  input  logic [VA_W-1:0] rspData,
  output logic            startFin,
  output logic            entryFin,
  output logic [VA_W-1:0] tableAddr,
  output logic [VA_W-1:0] resAddr,
  output excCode_e        resExc
);
  logic [VA_W-1:0] vaReg, asceReg, ptrReg, resReg;
  logic            wrReg, lsReg, lrReg, protReg;
  level_e          levelReg;
  excCode_e        excReg;

  function automatic logic [IDX_W-1:0] idxOf(input logic [VA_W-1:0] va, input level_e lv);
    logic [VA_W-1:0] sh;
    sh = va >> (SX_LSB + int'(lv[1:0]) * IDX_W);
    return sh[IDX_W-1:0];
  endfunction

  function automatic logic [VA_W-1:0] entOff(input logic [IDX_W-1:0] idx);
    return VA_W'(idx) << ENT_SHIFT;
  endfunction

  // Start of walk: real-space bypass, upper-index and first-length checks
  step_t           st;
  level_e          startLv;
  logic            upperSet;
  logic [IDX_W-1:0] startIdx;

  always_comb begin
    startLv  = level_e'({1'b0, asceReg[TT_LSB+1:TT_LSB]});
    startIdx = idxOf(vaReg, startLv);
    upperSet = 1'b0;
    for (int lv = 0; lv < IDX_LEVELS; lv++) begin
      if (lv > int'(startLv[1:0]))
        upperSet = upperSet | (idxOf(vaReg, level_e'(3'(lv))) != '0);
    end
    st       = '0;
    st.exc   = EXC_NONE;
    st.level = startLv;
    if (asceReg[B_REAL]) begin
      st.fin  = 1'b1;
      st.addr = vaReg;
    end else if (upperSet) begin
      st.fin = 1'b1;
      st.exc = EXC_SPACETYPE;
    end else if (startIdx[IDX_W-1 -: 2] > asceReg[TL_LSB+1:TL_LSB]) begin
      st.fin = 1'b1;
      st.exc = levelExc(startLv);
    end else begin
      st.ptr = (asceReg & TBL_MASK) + entOff(startIdx);
    end
  end

  // Per-entry evaluation
  step_t           en;
  level_e          nextLv;
  logic [IDX_W-1:0] nextIdx;
  logic [1:0]      nextTop;
  logic [VA_W-1:0] pageOff;

  always_comb begin
    nextLv   = level_e'(levelReg - 3'd1);
    nextIdx  = idxOf(vaReg, nextLv);
    nextTop  = nextIdx[IDX_W-1 -: 2];
    pageOff  = VA_W'(vaReg[SX_LSB-1:BX_W]) << ENT_SHIFT;
    en       = '0;
    en.exc   = EXC_NONE;
    en.level = levelReg;
    en.prot  = protReg;
    if (levelReg == LV_PAGE) begin
      en.fin = 1'b1;
      if (rspData[B_PGINV]) begin
        en.exc = EXC_PAGE;
      end else if (rspData[B_ZERO] || (rspData[B_CRO] && !lsReg)) begin
        en.exc = EXC_SPEC;
      end else begin
        en.prot = protReg | rspData[B_PROT];
        en.addr = (rspData & PFR_MASK) | (vaReg & ~PFR_MASK);
      end
    end else if (rspData[B_INV]) begin
      en.fin = 1'b1;
      en.exc = levelExc(levelReg);
    end else if (rspData[TT_LSB+1:TT_LSB] != levelReg[1:0]) begin
      en.fin = 1'b1;
      en.exc = EXC_SPEC;
    end else if (levelReg == LV_SEG) begin
      en.prot = protReg | rspData[B_PROT];
      if (lsReg && rspData[B_FC]) begin
        en.fin  = 1'b1;
        en.addr = (rspData & SFR_MASK) | (vaReg & ~SFR_MASK);
      end else begin
        en.ptr   = (rspData & PT_MASK) + pageOff;
        en.level = LV_PAGE;
      end
    end else if (levelReg == LV_RT && lrReg && rspData[B_FC]) begin
      en.fin  = 1'b1;
      en.prot = protReg | rspData[B_PROT];
      en.addr = (rspData & RFR_MASK) | (vaReg & ~RFR_MASK);
    end else if (nextTop < rspData[TF_LSB+1:TF_LSB] ||
                 nextTop > rspData[TL_LSB+1:TL_LSB]) begin
      en.fin = 1'b1;
      en.exc = levelExc(nextLv);
    end else begin
      en.prot  = protReg | (lsReg & rspData[B_PROT]);
      en.ptr   = (rspData & TBL_MASK) + entOff(nextIdx);
      en.level = nextLv;
    end
    if (en.fin && en.exc == EXC_NONE && wrReg && en.prot) begin
      en.exc  = EXC_PROT;
      en.addr = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      asceReg  <= '0;
      wrReg    <= 1'b0;
      lsReg    <= 1'b0;
      lrReg    <= 1'b0;
      protReg  <= 1'b0;
      levelReg <= LV_SEG;
      ptrReg   <= '0;
      resReg   <= '0;
      excReg   <= EXC_NONE;
    end else if (strobe.capture) begin
      vaReg    <= reqVaddr;
      asceReg  <= reqAsce;
      wrReg    <= reqWrite;
      lsReg    <= largeSegEn;
      lrReg    <= largeRegEn;
      protReg  <= 1'b0;
      levelReg <= LV_SEG;
      ptrReg   <= '0;
      resReg   <= '0;
      excReg   <= EXC_NONE;
    end else if (strobe.applyStart) begin
      levelReg <= st.level;
      ptrReg   <= st.ptr;
      if (st.fin) begin
        excReg <= st.exc;
        resReg <= st.addr;
      end
    end else if (strobe.applyEntry) begin
      levelReg <= en.level;
      ptrReg   <= en.ptr;
      protReg  <= en.prot;
      if (en.fin) begin
        excReg <= en.exc;
        resReg <= en.addr;
      end
    end
  end

  assign startFin  = st.fin;
  assign entryFin  = en.fin;
  assign tableAddr = ptrReg;
  assign resAddr   = resReg;
  assign resExc    = excReg;

  p_real_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyStart && asceReg[B_REAL] |=> excReg == EXC_NONE && resReg == vaReg);

  p_prot_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyEntry && entryFin && wrReg && en.prot |=> excReg != EXC_NONE);
endmodule

// File: rtl/addrWalker.sv
module addrWalker
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [63:0] reqVaddr,
  input  logic [63:0] reqAsce,
  input  logic        largeSegEn,
  input  logic        largeRegEn,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        done,
  output logic [63:0] doneAddr,
  output logic [3:0]  doneExc
);
  strobe_t  strobe;
  logic     startFin, entryFin;
  excCode_e resExc;

  walkCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .startFin    (startFin),
    .entryFin    (entryFin),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .done        (done),
    .strobe      (strobe)
  );

  walkPath i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqAsce    (reqAsce),
    .reqWrite   (reqWrite),
    .largeSegEn (largeSegEn),
    .largeRegEn (largeRegEn),
    .rspData    (memRspData),
    .startFin   (startFin),
    .entryFin   (entryFin),
    .tableAddr  (memReqAddr),
    .resAddr    (doneAddr),
    .resExc     (resExc)
  );

  assign doneExc = 4'(resExc);

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  p_aligned_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);

  p_fail_zero_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && doneExc != 4'd0 |-> doneAddr == 64'd0);
endmodule

// File: tb/test_addrWalker.sv
module test_addrWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic [63:0] reqAsce = '0;
  logic        largeSegEn = 1'b0;
  logic        largeRegEn = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done;
  logic [63:0] doneAddr;
  logic [3:0]  doneExc;

  always #10 clk = ~clk;

  addrWalker i_addrWalker (.*);

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [63:0] mem [longint unsigned];
  logic [63:0] expReads [$];

  localparam logic [63:0] FRAME = 64'h0000_0000_0077_7000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdMem(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [10:0] ix(input logic [63:0] va, input int lv);
    return 11'((va >> (20 + 11 * lv)) & 64'h7ff);
  endfunction

  function automatic logic [63:0] orgOf(input int lv);
    return 64'h10000 * 64'(lv < 4 ? 4 - lv : 5);
  endfunction

  function automatic logic [63:0] entAddr(input int lv, input logic [63:0] va);
    if (lv == 4) return orgOf(4) + 64'(va[19:12]) * 8;
    return orgOf(lv) + 64'(ix(va, lv)) * 8;
  endfunction

  function automatic logic [63:0] asceFor(input int dt, input int tl, input bit real_);
    return orgOf(dt) | (64'(real_) << 5) | (64'(dt) << 2) | 64'(tl);
  endfunction

  task automatic buildChain(input logic [63:0] va);
    for (int lv = 3; lv >= 1; lv--)
      mem[entAddr(lv, va)] = orgOf(lv - 1) | (64'(lv) << 2) | 64'd3;
    mem[entAddr(0, va)] = orgOf(4);
    mem[entAddr(4, va)] = FRAME;
  endtask

  task automatic flip(input int lv, input logic [63:0] va, input logic [63:0] bits);
    mem[entAddr(lv, va)] = rdMem(entAddr(lv, va)) ^ bits;
  endtask

  // Behavioural reference of the walk
  task automatic refWalk(input logic [63:0] va, input logic [63:0] asce,
                         input bit wr, input bit ls, input bit lr,
                         output logic [3:0] exc, output logic [63:0] pa);
    int st;
    bit prot, fin;
    logic [63:0] ptr, e;
    logic [1:0] t;
    expReads.delete();
    exc = 0; pa = 0; prot = 0; fin = 0;
    if (asce[5]) begin pa = va; return; end
    st = int'(asce[3:2]);
    for (int lv = 3; lv > st; lv--)
      if (ix(va, lv) != 0) begin exc = 1; return; end
    if (ix(va, st) >> 9 > 11'(asce[1:0])) begin exc = 4'(5 - st); return; end
    ptr = {asce[63:12], 12'h0} + 64'(ix(va, st)) * 8;
    for (int lv = st; lv >= 0 && !fin; lv--) begin
      e = rdMem(ptr); expReads.push_back(ptr);
      if (e[5]) begin exc = 4'(5 - lv); return; end
      if (int'(e[3:2]) != lv) begin exc = 7; return; end
      if (lv == 1 && lr && e[10]) begin
        prot |= e[9]; pa = {e[63:31], va[30:0]}; fin = 1;
      end else if (lv == 0) begin
        prot |= e[9];
        if (ls && e[10]) begin pa = {e[63:20], va[19:0]}; fin = 1; end
        else ptr = {e[63:11], 11'h0} + 64'(va[19:12]) * 8;
      end else begin
        t = 2'(ix(va, lv - 1) >> 9);
        if (t < e[7:6] || t > e[1:0]) begin exc = 4'(6 - lv); return; end
        if (ls) prot |= e[9];
        ptr = {e[63:12], 12'h0} + 64'(ix(va, lv - 1)) * 8;
      end
    end
    if (!fin) begin
      e = rdMem(ptr); expReads.push_back(ptr);
      if (e[10]) begin exc = 6; return; end
      if (e[11] || (e[8] && !ls)) begin exc = 7; return; end
      prot |= e[9];
      pa = {e[63:12], va[11:0]};
    end
    if (wr && prot) begin exc = 8; pa = 0; end
  endtask

  // Table memory responder, one read outstanding; also checks each read address
  bit pend = 0;
  logic [63:0] pendAddr;
  always @(negedge clk) begin
    cycles++;
    memRspValid = 1'b0;
    if (pend) begin
      memRspValid = 1'b1;
      memRspData  = rdMem(pendAddr);
      pend = 0;
    end else if (rstN && memReqValid) begin
      if (expReads.size() == 0) chk(0, "R4", "unexpected read", memReqAddr, 64'd0);
      else begin
        logic [63:0] ea;
        ea = expReads.pop_front();
        chk(memReqAddr == ea, "R4", "read address", memReqAddr, ea);
      end
      pend = 1;
      pendAddr = memReqAddr;
    end
  end

  task automatic doWalk(input string tag, input logic [63:0] va, input logic [63:0] asce,
                        input bit wr, input bit ls, input bit lr);
    logic [3:0] eExc;
    logic [63:0] eAddr;
    int n;
    refWalk(va, asce, wr, ls, lr, eExc, eAddr);
    @(negedge clk);
    reqVaddr = va; reqAsce = asce; reqWrite = wr;
    largeSegEn = ls; largeRegEn = lr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R11", "busy after accept", 64'(reqReady), 64'd0);
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    if (!done) begin
      chk(0, tag, "walk timeout", 64'd0, 64'd1);
      return;
    end
    chk(doneExc == eExc, tag, "exception code", 64'(doneExc), 64'(eExc));
    chk(doneAddr == eAddr, tag, "result address", doneAddr, eAddr);
    chk(expReads.size() == 0, "R4", "missing reads", 64'(expReads.size()), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    chk(0, "R11", "watchdog expired", 64'(cycles), 64'd150000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [63:0] va0, va1, va2, va, bitSel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R12", "ready after reset", 64'(reqReady), 64'd1);
    chk(memReqValid == 1'b0, "R12", "no read after reset", 64'(memReqValid), 64'd0);
    chk(done == 1'b0, "R12", "no done after reset", 64'(done), 64'd0);

    va0 = {11'd1, 11'd2, 11'd3, 11'd4, 8'd5, 12'h123};
    va1 = {11'd0, 11'd0, 11'd3, 11'd4, 8'd5, 12'h456};
    va2 = {11'h600, 11'd2, 11'd3, 11'd4, 8'd5, 12'h123};
    buildChain(va0);
    doWalk("R1", va0, asceFor(3, 3, 1), 1, 0, 0);
    doWalk("R2", va0, asceFor(0, 3, 0), 0, 0, 0);
    doWalk("R2", va0, asceFor(2, 3, 0), 0, 0, 0);
    buildChain(va2);
    doWalk("R3", va2, asceFor(3, 1, 0), 0, 0, 0);
    doWalk("R4", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va1);
    doWalk("R4", va1, asceFor(1, 3, 0), 0, 0, 0);
    flip(2, va0, 64'h20);
    doWalk("R5", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(1, va0, 64'h0c);
    doWalk("R5", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(4, va0, 64'h400);
    doWalk("R5", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(3, va0, 64'h40);
    doWalk("R6", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(1, va0, 64'h3 | 64'h400 | 64'h0000_0012_8000_0000);
    doWalk("R7", va0, asceFor(3, 3, 0), 0, 1, 1);
    doWalk("R7", va0, asceFor(3, 3, 0), 0, 1, 0);
    buildChain(va0); flip(0, va0, 64'h400 | 64'h0000_0abc_0000_0000);
    doWalk("R8", va0, asceFor(3, 3, 0), 0, 1, 0);
    doWalk("R8", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(4, va0, 64'h200);
    doWalk("R9", va0, asceFor(3, 3, 0), 1, 0, 0);
    doWalk("R9", va0, asceFor(3, 3, 0), 0, 0, 0);
    buildChain(va0); flip(2, va0, 64'h200);
    doWalk("R9", va0, asceFor(3, 3, 0), 1, 0, 0);
    doWalk("R9", va0, asceFor(3, 3, 0), 1, 1, 0);
    buildChain(va0); flip(4, va0, 64'h800);
    doWalk("R10", va0, asceFor(3, 3, 0), 0, 1, 0);
    buildChain(va0); flip(4, va0, 64'h100);
    doWalk("R10", va0, asceFor(3, 3, 0), 0, 0, 0);
    doWalk("R10", va0, asceFor(3, 3, 0), 0, 1, 0);

    for (int k = 0; k < 200; k++) begin
      int dt, tl;
      dt = int'($urandom % 4);
      tl = int'($urandom % 4);
      va = {$urandom, $urandom};
      if ($urandom % 4 != 0)
        for (int lv = 3; lv > dt; lv--) va &= ~(64'h7ff << (20 + 11 * lv));
      if ($urandom % 2 == 0) va &= ~(64'h3 << (29 + 11 * dt));
      buildChain(va);
      for (int lv = 0; lv <= 4; lv++) begin
        if ($urandom % 5 == 0) begin
          case ($urandom % 10)
            0: bitSel = 64'h20;   1: bitSel = 64'h200;  2: bitSel = 64'h400;
            3: bitSel = 64'h800;  4: bitSel = 64'h100;  5: bitSel = 64'h40;
            6: bitSel = 64'h80;   7: bitSel = 64'h1;    8: bitSel = 64'h4;
            default: bitSel = 64'h2;
          endcase
          flip(lv, va, bitSel);
        end
      end
      doWalk("R9", va, asceFor(dt, tl, ($urandom % 12) == 0),
             1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule